// File: doc/BRIEF.md
# Packed Pixel Word Unpacker

This block feeds a two-bit-per-channel resistor colour DAC from a pixel FIFO whose read side runs on the pixel clock. The write side of the FIFO runs on its own clock, so the FIFO absorbs the clock difference. Every FIFO word is 18 bits wide and packs three 6-bit pixels, so 64 colours are available. The block holds one word, shows its three pixels on three successive active pixel clocks, and pulls the next word from the FIFO only while the third pixel is on screen. This cuts the FIFO read rate to one word per three pixels.

An external timing generator supplies an active-video qualifier and a frame-start pulse. Outside active video the colour outputs are black and the pixel position within the held word is frozen. If the display needs a pixel while no word is held, the block shows black, sets a sticky underrun flag and waits for data without moving its position. Sync generation and the FIFO itself belong to other blocks.

Top module: `pixel_unpacker`

## Requirements
- R1: While reset is asserted and the FIFO is empty, `fifo_rd` is 0, all colour outputs are 0 and `underrun` is 0. Reset leaves no word held, with the pixel position at pixel 0.
- R2: Pixel 0 of a word is bits [5:0], pixel 1 is bits [11:6] and pixel 2 is bits [17:12]. Within a pixel, red is bits [5:4], green is [3:2] and blue is [1:0].
- R3: On consecutive active cycles with a word held, the colour outputs show pixel 0, then pixel 1, then pixel 2 of that word. On the next active cycle they show pixel 0 of the following word.
- R4: `fifo_rd` is high for one cycle when the FIFO is not empty and either no word is held or pixel 2 is being shown during active video. The popped `fifo_data` word is held from the next clock, and its pixel 0 is the next pixel shown.
- R5: While `active` is low, red, green and blue are all 0 and the pixel position does not change.
- R6: An active cycle with no word held shows black, and `underrun` goes high on the next clock. It then stays high until reset.
- R7: After an underrun, the first word to arrive is shown from its pixel 0. No pixel position is skipped while data is missing.
- R8: A cycle with `frame_start` high sets the position to pixel 0 from the next clock. The held word is kept.
- R9: `fifo_rd` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| active | input | 1 | High during visible pixels |
| fifo_data | input | 18 | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop strobe to the FIFO |
| red | output | 2 | Red DAC code |
| grn | output | 2 | Green DAC code |
| blu | output | 2 | Blue DAC code |
| underrun | output | 1 | Sticky flag: a pixel was needed but no data was held |

## Verification
`fifo_rd` and the colour outputs are combinational from the inputs and the held state, so they are due in the same cycle as the stimulus. A pop, a frame-start restart or a position advance shows up one clock later, and `underrun` rises one clock after the starved active cycle. The bench changes inputs just after each falling edge. It compares a queue-based model against the ports one time unit later, and then advances the model at the rising edge. Every field is therefore checked in the cycle it is due.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int DEF_CH_W = 2;
  localparam int DEF_PIX_PER_WORD = 3;
  localparam int CHANNELS = 3;

  function automatic int phase_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pxu_phase.sv
module pxu_phase #(
  parameter int PPW = 3,
  parameter int PW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          restart,
  output logic [PW-1:0] phase,
  output logic          last
);
  logic [PW-1:0] ph_q, ph_d;

  assign last  = (ph_q == PW'(PPW - 1));
  assign phase = ph_q;

  always_comb begin
    ph_d = ph_q;
    if (restart)      ph_d = '0;
    else if (advance) ph_d = last ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/pxu_word.sv
module pxu_word #(
  parameter int WW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          consume,
  input  logic [WW-1:0] din,
  output logic [WW-1:0] word,
  output logic          have
);
  logic [WW-1:0] word_q;
  logic          have_q, have_d;

  always_comb begin
    have_d = have_q;
    if (load)         have_d = 1'b1;
    else if (consume) have_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) have_q <= 1'b0;
    else        have_q <= have_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= din;
  end

  assign word = word_q;
  assign have = have_q;
endmodule

// File: rtl/pxu_select.sv
module pxu_select #(
  parameter int CH_W = 2,
  parameter int PPW  = 3,
  parameter int PW   = 2,
  localparam int PIX_W = pxu_pkg::CHANNELS * CH_W,
  localparam int WW    = PIX_W * PPW
) (
  input  logic [WW-1:0]   word,
  input  logic [PW-1:0]   phase,
  input  logic            show,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] grn,
  output logic [CH_W-1:0] blu
);
  logic [PIX_W-1:0] slot [PPW];
  logic [PIX_W-1:0] pix;

  for (genvar g = 0; g < PPW; g++) begin : g_slot
    assign slot[g] = word[g*PIX_W +: PIX_W];
  end

  always_comb begin
    pix = '0;
    for (int i = 0; i < PPW; i++)
      if (phase == PW'(i)) pix = slot[i];
    if (!show) pix = '0;
  end

  assign red = pix[3*CH_W-1 -: CH_W];
  assign grn = pix[2*CH_W-1 -: CH_W];
  assign blu = pix[CH_W-1:0];
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker #(
  parameter int CH_W = pxu_pkg::DEF_CH_W,
  parameter int PPW  = pxu_pkg::DEF_PIX_PER_WORD,
  localparam int PIX_W = pxu_pkg::CHANNELS * CH_W,
  localparam int WW    = PIX_W * PPW,
  localparam int PW    = pxu_pkg::phase_width(PPW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            active,
  input  logic [WW-1:0]   fifo_data,
  input  logic            fifo_empty,
  output logic            fifo_rd,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] grn,
  output logic [CH_W-1:0] blu,
  output logic            underrun
);
  logic [WW-1:0] word;
  logic [PW-1:0] phase;
  logic          have, last, show, consume, need;
  logic          ur_q, ur_d;

  assign show    = active & have;
  assign consume = show & last;
  assign need    = ~have | consume;
  assign fifo_rd = need & ~fifo_empty;

  pxu_phase #(.PPW(PPW), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .advance(show), .restart(frame_start),
    .phase(phase), .last(last)
  );

  pxu_word #(.WW(WW)) u_word (
    .clk(clk), .rst_n(rst_n), .load(fifo_rd), .consume(consume),
    .din(fifo_data), .word(word), .have(have)
  );

  pxu_select #(.CH_W(CH_W), .PPW(PPW), .PW(PW)) u_sel (
    .word(word), .phase(phase), .show(show),
    .red(red), .grn(grn), .blu(blu)
  );

  always_comb ur_d = ur_q | (active & ~have);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ur_q <= 1'b0;
    else        ur_q <= ur_d;
  end

  assign underrun = ur_q;
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            active,
  input logic            fifo_empty,
  input logic            fifo_rd,
  input logic [CH_W-1:0] red,
  input logic [CH_W-1:0] grn,
  input logic [CH_W-1:0] blu,
  input logic            underrun
);
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty); // R9
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd); // R4
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (red == '0 && grn == '0 && blu == '0)); // R5
  AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R6
  AST_UR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(active)); // R6
  AST_RESTART_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !active) |=> !(fifo_rd && $past(fifo_rd))); // R8
endmodule

bind pixel_unpacker pxu_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
  .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .red(red), .grn(grn),
  .blu(blu), .underrun(underrun)
);

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        active = 1'b0;
  logic [17:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd;
  logic [1:0]  red, grn, blu;
  logic        underrun;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [17:0] q[$];
  int          m_have = 0, m_ph = 0, m_ur = 0;
  logic [17:0] m_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_unpacker u_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .red(red), .grn(grn), .blu(blu), .underrun(underrun)
  );

  function automatic logic [17:0] mk(input int a, input int b, input int c);
    return {6'(c), 6'(b), 6'(a)};
  endfunction

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic act, input logic fs, input string tag);
    int e_rd, pix, n_have, n_ph;
    logic [17:0] n_word;
    active = act;
    frame_start = fs;
    fifo_empty = (q.size() == 0);
    fifo_data = (q.size() != 0) ? q[0] : 18'h2AAAA;
    #1;
    e_rd = (q.size() != 0) && (m_have == 0 || (act && m_ph == 2)) ? 1 : 0;
    pix = (act && m_have != 0) ? int'((m_word >> (6*m_ph)) & 18'h3F) : 0;
    vectors++;
    cmp(tag, "fifo_rd (R4/R9)", int'(fifo_rd), e_rd);
    cmp(tag, "red (R2/R3/R5)", int'(red), (pix >> 4) & 3);
    cmp(tag, "grn (R2/R3/R5)", int'(grn), (pix >> 2) & 3);
    cmp(tag, "blu (R2/R3/R5)", int'(blu), pix & 3);
    cmp(tag, "underrun (R6)", int'(underrun), m_ur);
    n_have = m_have; n_word = m_word; n_ph = m_ph;
    if (act && m_have == 0) m_ur = 1;
    if (act && m_have != 0) n_ph = (m_ph == 2) ? 0 : m_ph + 1;
    if (fs) n_ph = 0;
    if (e_rd != 0) begin
      n_word = q[0];
      n_have = 1;
    end else if (act && m_have != 0 && m_ph == 2) begin
      n_have = 0;
    end
    @(posedge clk);
    if (e_rd != 0) void'(q.pop_front());
    m_have = n_have; m_word = n_word; m_ph = n_ph;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    cmp("R1", "fifo_rd", int'(fifo_rd), 0);
    cmp("R1", "rgb", int'({red, grn, blu}), 0);
    cmp("R1", "underrun", int'(underrun), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: each colour field at full scale in each pixel slot
    q.push_back(mk(6'h30, 6'h0C, 6'h03));
    q.push_back(mk(6'h03, 6'h30, 6'h0C));
    q.push_back(mk(6'h0C, 6'h03, 6'h30));
    q.push_back(mk(6'h15, 6'h2A, 6'h3F));
    step(0, 0, "R4");
    step(0, 0, "R4");
    for (int i = 0; i < 12; i++) step(1, 0, "R3");
    // starvation
    for (int i = 0; i < 3; i++) step(1, 0, "R6");
    q.push_back(mk(6'h21, 6'h12, 6'h09));
    for (int i = 0; i < 4; i++) step(1, 0, "R7");
    // gaps in active video mid-word
    q.push_back(mk(6'h01, 6'h02, 6'h04));
    q.push_back(mk(6'h08, 6'h10, 6'h20));
    q.push_back(mk(6'h3E, 6'h3D, 6'h3B));
    for (int i = 0; i < 14; i++) step((i % 3) != 1, 0, "R5");
    // frame restart mid-word
    q.push_back(mk(6'h11, 6'h22, 6'h33));
    q.push_back(mk(6'h05, 6'h0A, 6'h14));
    step(1, 0, "R8");
    step(1, 0, "R8");
    step(0, 1, "R8");
    for (int i = 0; i < 6; i++) step(1, 0, "R8");
    step(1, 1, "R8");
    for (int i = 0; i < 5; i++) step(1, 0, "R8");
    // empty FIFO must never be popped
    for (int i = 0; i < 4; i++) step(i[0], 0, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule